// File: doc/BRIEF.md
# Write Buffer with Read-Miss Bypass

This block sits between a write-through data cache and the next memory level. Stores from the cache are placed in a small first-in first-out queue and leave toward memory one per memory handshake. The processor does not wait on those stores unless the queue is full.

A read miss presented to the block is compared against every address still held in the queue. On a match, the block answers the read itself, one cycle later, with the value of the most recently queued store to that word. On no match, the read is sent to memory at once, ahead of the stores still waiting. A parameter selects a simpler mode in which an unmatched read first waits for the queue to empty. Only one read is handled at a time. A read request always takes precedence over a store offered in the same cycle. Addresses are word addresses, and every store writes a whole word.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset, and after any reset applied in mid-operation, the queue is empty. In that state `wr_ready` and `rd_req_ready` are 1, and `mem_req_valid` and `rd_resp_valid` are 0.
- R2: A store is accepted on a cycle where `wr_valid` and `wr_ready` are both 1. `wr_ready` is 0 while DEPTH entries are held, and a store offered in that state is discarded and never reaches memory.
- R3: Queued stores are presented on the memory port with `mem_req_write`=1 in arrival order. The address and data of the oldest entry are held until `mem_req_ready` is 1, and each handshake removes exactly one entry.
- R4: A read whose address matches a queued entry is accepted while idle. `rd_resp_valid` is 1 in the following cycle with that entry's data, and no memory read is issued.
- R5: When several queued entries match the read address, the data returned is that of the most recently queued one.
- R6: With WAIT_EMPTY=0, an unmatched read appears on the memory port (`mem_req_valid`=1, `mem_req_write`=0, `mem_req_addr` = the read address) in the cycle after acceptance, even while stores are queued. Queued stores resume once the read handshake has completed.
- R7: After a memory read is issued, the first cycle with `mem_resp_valid`=1 yields `rd_resp_valid`=1 in the next cycle, with `rd_resp_data` equal to `mem_resp_data`. `rd_resp_valid` is a single-cycle pulse.
- R8: With WAIT_EMPTY=1, an unmatched read is not presented to memory while any store is queued. Stores keep draining, and the read is issued in the cycle after the queue is observed empty.
- R9: `wr_ready` is 0 whenever `rd_req_valid` is 1, and whenever a read miss is in progress.
- R10: A store that has completed its memory handshake no longer matches. A later read to its address goes to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Store offered |
| wr_ready | output | 1 | Store can be taken this cycle |
| wr_addr | input | AW | Store word address |
| wr_data | input | DW | Store data |
| rd_req_valid | input | 1 | Read miss offered |
| rd_req_ready | output | 1 | Read miss can be taken this cycle |
| rd_addr | input | AW | Read miss word address |
| rd_resp_valid | output | 1 | Read data pulse |
| rd_resp_data | output | DW | Read data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = store, 0 = read |
| mem_req_addr | output | AW | Memory request address |
| mem_req_data | output | DW | Store data toward memory |
| mem_resp_valid | input | 1 | Memory read data present |
| mem_resp_data | input | DW | Memory read data |

## Verification
A corrupted queue pointer or occupancy count appears on the very next memory-side request as a store at the wrong address or with the wrong data. It can also appear as a store sent twice, or as `wr_ready` that disagrees with the number of stores accepted. A fault in the comparison or the age ordering shows one cycle after the read is accepted. Either the wrong word comes back, or a read appears on the memory port when it should have been answered locally. A read state machine stuck in the wrong state shows within a cycle as `wr_ready` held low, or as a read issued while stores are still queued in the wait-for-empty mode.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // read-miss handling phases
  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,  // free; reads and stores may be taken
    RS_HOLD  = 2'd1,  // miss waiting for the queue to empty
    RS_ISSUE = 2'd2,  // read presented on the memory port
    RS_WAIT  = 2'd3   // read accepted by memory, awaiting data
  } rd_state_e;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          enq,
  input  logic [AW-1:0]                 enq_addr,
  input  logic [DW-1:0]                 enq_data,
  input  logic                          deq,
  output logic [PTR_W-1:0]              head_ptr,
  output logic [CNT_W-1:0]              count,
  output logic [DEPTH-1:0][AW-1:0]      slot_addr,
  output logic [DEPTH-1:0][DW-1:0]      slot_data
);
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;

  // entry storage, written without reset
  always_ff @(posedge clk) begin
    if (enq) begin
      slot_addr[wp] <= enq_addr;
      slot_data[wp] <= enq_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (enq) wp <= wp + 1'b1;
      if (deq) rp <= rp + 1'b1;
      case ({enq, deq})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head_ptr = rp;
  assign count    = cnt;
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic [DEPTH-1:0][AW-1:0] slot_addr,
  input  logic [DEPTH-1:0][DW-1:0] slot_data,
  input  logic [PTR_W-1:0]         head_ptr,
  input  logic [CNT_W-1:0]         count,
  input  logic [AW-1:0]            q_addr,
  output logic                     hit,
  output logic [DW-1:0]            hit_data
);
  // per-slot equality and liveness, one comparator per slot
  logic [DEPTH-1:0] eq_vec;
  logic [DEPTH-1:0] live_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [PTR_W-1:0] age;
    assign age         = PTR_W'(g) - head_ptr;
    assign live_vec[g] = ({1'b0, age} < count);
    assign eq_vec[g]   = (slot_addr[g] == q_addr);
  end

  // walk from oldest to youngest so the youngest match is left standing
  logic [PTR_W-1:0] idx;
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    idx      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_ptr + PTR_W'(k);
      if (live_vec[idx] && eq_vec[idx]) begin
        hit      = 1'b1;
        hit_data = slot_data[idx];
      end
    end
  end
endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter bit WAIT_EMPTY = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic          hit,
  input  logic [DW-1:0] hit_data,
  input  logic          q_empty,
  input  logic          mem_req_ready,
  input  logic          mem_resp_valid,
  input  logic [DW-1:0] mem_resp_data,
  output rd_state_e     state,
  output logic [AW-1:0] miss_addr,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data
);
  rd_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= RS_IDLE;
      miss_addr  <= '0;
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (st)
        RS_IDLE: begin
          if (rd_req_valid) begin
            if (hit) begin
              resp_valid <= 1'b1;
              resp_data  <= hit_data;
            end else begin
              miss_addr <= rd_addr;
              st        <= WAIT_EMPTY ? RS_HOLD : RS_ISSUE;
            end
          end
        end
        RS_HOLD:  if (q_empty) st <= RS_ISSUE;
        RS_ISSUE: if (mem_req_ready) st <= RS_WAIT;
        RS_WAIT: begin
          if (mem_resp_valid) begin
            resp_valid <= 1'b1;
            resp_data  <= mem_resp_data;
            st         <= RS_IDLE;
          end
        end
        default: st <= RS_IDLE;
      endcase
    end
  end

  assign state = st;
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass
  import wbuf_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int DEPTH      = 4,
  parameter bit WAIT_EMPTY = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req_valid,
  output logic          rd_req_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_data,
  input  logic          mem_resp_valid,
  input  logic [DW-1:0] mem_resp_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [PTR_W-1:0]         head_ptr;
  logic [CNT_W-1:0]         occ;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0][DW-1:0] slot_data;
  logic                     rd_hit;
  logic [DW-1:0]            rd_hit_data;
  rd_state_e                st;
  logic [AW-1:0]            miss_addr;
  logic                     q_empty, q_full, rd_out, enq, deq;

  assign q_empty = (occ == '0);
  assign q_full  = (occ == CNT_W'(DEPTH));
  assign rd_out  = (st == RS_ISSUE);

  assign rd_req_ready = (st == RS_IDLE);
  assign wr_ready     = (st == RS_IDLE) && !q_full && !rd_req_valid;
  assign enq          = wr_valid && wr_ready;
  assign deq          = !rd_out && !q_empty && mem_req_ready;

  assign mem_req_valid = rd_out || !q_empty;
  assign mem_req_write = !rd_out;
  assign mem_req_addr  = rd_out ? miss_addr : slot_addr[head_ptr];
  assign mem_req_data  = slot_data[head_ptr];

  wbuf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .enq(enq), .enq_addr(wr_addr), .enq_data(wr_data),
    .deq(deq),
    .head_ptr(head_ptr), .count(occ),
    .slot_addr(slot_addr), .slot_data(slot_data)
  );

  wbuf_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
    .slot_addr(slot_addr), .slot_data(slot_data),
    .head_ptr(head_ptr), .count(occ),
    .q_addr(rd_addr),
    .hit(rd_hit), .hit_data(rd_hit_data)
  );

  wbuf_ctrl #(.AW(AW), .DW(DW), .WAIT_EMPTY(WAIT_EMPTY)) u_ctrl (
    .clk(clk), .rst(rst),
    .rd_req_valid(rd_req_valid), .rd_addr(rd_addr),
    .hit(rd_hit), .hit_data(rd_hit_data),
    .q_empty(q_empty),
    .mem_req_ready(mem_req_ready),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .state(st), .miss_addr(miss_addr),
    .resp_valid(rd_resp_valid), .resp_data(rd_resp_data)
  );
endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk
  import wbuf_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int DEPTH      = 4,
  parameter bit WAIT_EMPTY = 1'b0,
  parameter int CNT_W      = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic            rd_req_valid,
  input logic            rd_req_ready,
  input logic            rd_hit,
  input logic [CNT_W-1:0] occ,
  input rd_state_e       st,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_write,
  input logic [AW-1:0]   mem_req_addr,
  input logic [DW-1:0]   mem_req_data,
  input logic            mem_resp_valid,
  input logic [DW-1:0]   mem_resp_data,
  input logic            rd_resp_valid,
  input logic [DW-1:0]   rd_resp_data
);
  p_full_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (occ == CNT_W'(DEPTH)) |-> !wr_ready);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> (occ != '0));

  p_store_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write && !mem_req_ready)
      |=> mem_req_valid && (!mem_req_write ||
          ($stable(mem_req_addr) && $stable(mem_req_data))));

  p_hit_local_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && rd_req_ready && rd_hit)
      |=> rd_resp_valid && !(mem_req_valid && !mem_req_write));

  p_miss_issue_r6: assert property (@(posedge clk) disable iff (rst)
    (!WAIT_EMPTY && rd_req_valid && rd_req_ready && !rd_hit)
      |=> mem_req_valid && !mem_req_write);

  p_resp_copy_r7: assert property (@(posedge clk) disable iff (rst)
    (st == RS_WAIT && mem_resp_valid)
      |=> rd_resp_valid && (rd_resp_data == $past(mem_resp_data)));

  p_wait_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (WAIT_EMPTY && mem_req_valid && !mem_req_write) |-> (occ == '0));

  p_read_first_r9: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> !wr_ready);
endmodule

bind wbuf_bypass wbuf_bypass_chk #(
  .AW(AW), .DW(DW), .DEPTH(DEPTH), .WAIT_EMPTY(WAIT_EMPTY), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst),
  .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_hit(rd_hit), .occ(occ), .st(st),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_data(mem_req_data),
  .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
  .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data)
);

// File: tb/wbuf_bypass_test.sv
module wbuf_bypass_test;
  localparam int AW = 16;
  localparam int DW = 32;

  typedef struct packed {
    logic          wv;  logic [AW-1:0] wa;  logic [DW-1:0] wd;
    logic          rv;  logic [AW-1:0] ra;
    logic          mr;  logic          mrv; logic [DW-1:0] mrd;
    logic          ewr; logic          emv; logic          emw;
    logic [AW-1:0] ema; logic [DW-1:0] emd;
    logic          erv; logic [DW-1:0] erd;
    logic [3:0]    rq;
  } vec_t;

  // per-cycle stimulus and the outputs expected in that same cycle
  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    // fill: R2 (four accepted, fifth refused)
    '{1'b1,16'h10,32'h1, 1'b0,16'h0, 1'b0,1'b0,32'h0, 1'b1,1'b0,1'b0,16'h0,32'h0, 1'b0,32'h0, 4'd2},
    '{1'b1,16'h11,32'h2, 1'b0,16'h0, 1'b0,1'b0,32'h0, 1'b1,1'b1,1'b1,16'h10,32'h1, 1'b0,32'h0, 4'd2},
    '{1'b1,16'h10,32'h3, 1'b0,16'h0, 1'b0,1'b0,32'h0, 1'b1,1'b1,1'b1,16'h10,32'h1, 1'b0,32'h0, 4'd2},
    '{1'b1,16'h12,32'h4, 1'b0,16'h0, 1'b0,1'b0,32'h0, 1'b1,1'b1,1'b1,16'h10,32'h1, 1'b0,32'h0, 4'd2},
    '{1'b1,16'h13,32'h5, 1'b0,16'h0, 1'b0,1'b0,32'h0, 1'b0,1'b1,1'b1,16'h10,32'h1, 1'b0,32'h0, 4'd2},
    // R9: read offered, store side closed; R4/R5: hit on 0x10, youngest data 3
    '{1'b0,16'h0,32'h0,  1'b1,16'h10,1'b0,1'b0,32'h0, 1'b0,1'b1,1'b1,16'h10,32'h1, 1'b0,32'h0, 4'd9},
    '{1'b0,16'h0,32'h0,  1'b0,16'h0, 1'b0,1'b0,32'h0, 1'b0,1'b1,1'b1,16'h10,32'h1, 1'b1,32'h3, 4'd5},
    // R6: miss on 0x20 goes out ahead of four queued stores
    '{1'b0,16'h0,32'h0,  1'b1,16'h20,1'b0,1'b0,32'h0, 1'b0,1'b1,1'b1,16'h10,32'h1, 1'b0,32'h0, 4'd9},
    '{1'b0,16'h0,32'h0,  1'b0,16'h0, 1'b1,1'b0,32'h0, 1'b0,1'b1,1'b0,16'h20,32'h0, 1'b0,32'h0, 4'd6},
    // R3: stores resume in order while the read is outstanding
    '{1'b0,16'h0,32'h0,  1'b0,16'h0, 1'b1,1'b0,32'h0, 1'b0,1'b1,1'b1,16'h10,32'h1, 1'b0,32'h0, 4'd3},
    '{1'b0,16'h0,32'h0,  1'b0,16'h0, 1'b1,1'b1,32'h55,1'b0,1'b1,1'b1,16'h11,32'h2, 1'b0,32'h0, 4'd3},
    // R7: memory data returned
    '{1'b0,16'h0,32'h0,  1'b0,16'h0, 1'b0,1'b0,32'h0, 1'b1,1'b1,1'b1,16'h10,32'h3, 1'b1,32'h55, 4'd7},
    // R10: 0x11 already drained, so it misses
    '{1'b0,16'h0,32'h0,  1'b1,16'h11,1'b0,1'b0,32'h0, 1'b0,1'b1,1'b1,16'h10,32'h3, 1'b0,32'h0, 4'd10},
    '{1'b0,16'h0,32'h0,  1'b0,16'h0, 1'b1,1'b0,32'h0, 1'b0,1'b1,1'b0,16'h11,32'h0, 1'b0,32'h0, 4'd10},
    '{1'b0,16'h0,32'h0,  1'b0,16'h0, 1'b0,1'b1,32'h77,1'b0,1'b1,1'b1,16'h10,32'h3, 1'b0,32'h0, 4'd7},
    '{1'b1,16'h14,32'h6, 1'b0,16'h0, 1'b1,1'b0,32'h0, 1'b1,1'b1,1'b1,16'h10,32'h3, 1'b1,32'h77, 4'd7},
    // R3 / R2: remaining order 0x12, 0x14; refused 0x13 never appears
    '{1'b0,16'h0,32'h0,  1'b0,16'h0, 1'b1,1'b0,32'h0, 1'b1,1'b1,1'b1,16'h12,32'h4, 1'b0,32'h0, 4'd3},
    '{1'b0,16'h0,32'h0,  1'b0,16'h0, 1'b1,1'b0,32'h0, 1'b1,1'b1,1'b1,16'h14,32'h6, 1'b0,32'h0, 4'd3},
    '{1'b0,16'h0,32'h0,  1'b0,16'h0, 1'b0,1'b0,32'h0, 1'b1,1'b0,1'b0,16'h0,32'h0, 1'b0,32'h0, 4'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  // bypass-mode instance
  logic          wv = 0, rv = 0, mr = 0, mrv = 0;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [DW-1:0] wd = '0, mrd = '0;
  logic          wr_ready, rd_req_ready, rd_resp_valid;
  logic          mem_req_valid, mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] rd_resp_data, mem_req_data;

  wbuf_bypass #(.AW(AW), .DW(DW), .DEPTH(4), .WAIT_EMPTY(1'b0)) uut (
    .clk(clk), .rst(rst),
    .wr_valid(wv), .wr_ready(wr_ready), .wr_addr(wa), .wr_data(wd),
    .rd_req_valid(rv), .rd_req_ready(rd_req_ready), .rd_addr(ra),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mr),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_data(mem_req_data),
    .mem_resp_valid(mrv), .mem_resp_data(mrd)
  );

  // wait-for-empty instance
  logic          w_wv = 0, w_rv = 0, w_mr = 0, w_mrv = 0;
  logic [AW-1:0] w_wa = '0, w_ra = '0;
  logic [DW-1:0] w_wd = '0, w_mrd = '0;
  logic          w_wr_ready, w_rd_req_ready, w_rd_resp_valid;
  logic          w_mem_req_valid, w_mem_req_write;
  logic [AW-1:0] w_mem_req_addr;
  logic [DW-1:0] w_rd_resp_data, w_mem_req_data;

  wbuf_bypass #(.AW(AW), .DW(DW), .DEPTH(4), .WAIT_EMPTY(1'b1)) uut_w (
    .clk(clk), .rst(rst),
    .wr_valid(w_wv), .wr_ready(w_wr_ready), .wr_addr(w_wa), .wr_data(w_wd),
    .rd_req_valid(w_rv), .rd_req_ready(w_rd_req_ready), .rd_addr(w_ra),
    .rd_resp_valid(w_rd_resp_valid), .rd_resp_data(w_rd_resp_data),
    .mem_req_valid(w_mem_req_valid), .mem_req_ready(w_mr),
    .mem_req_write(w_mem_req_write), .mem_req_addr(w_mem_req_addr),
    .mem_req_data(w_mem_req_data),
    .mem_resp_valid(w_mrv), .mem_resp_data(w_mrd)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    #2;
    // R1: reset state on both instances
    chk(wr_ready == 1'b1,      "R1 wr_ready",      64'(wr_ready), 64'h1);
    chk(rd_req_ready == 1'b1,  "R1 rd_req_ready",  64'(rd_req_ready), 64'h1);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'h0);
    chk(rd_resp_valid == 1'b0, "R1 rd_resp_valid", 64'(rd_resp_valid), 64'h0);
    chk(w_mem_req_valid == 1'b0, "R1 wait mem_req_valid", 64'(w_mem_req_valid), 64'h0);
    @(negedge clk);

    // table walk on the bypass instance
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].rq, i);
      wv = VEC[i].wv; wa = VEC[i].wa; wd = VEC[i].wd;
      rv = VEC[i].rv; ra = VEC[i].ra;
      mr = VEC[i].mr; mrv = VEC[i].mrv; mrd = VEC[i].mrd;
      #2;
      chk(wr_ready == VEC[i].ewr, {tag, " wr_ready"}, 64'(wr_ready), 64'(VEC[i].ewr));
      chk(mem_req_valid == VEC[i].emv, {tag, " mem_req_valid"},
          64'(mem_req_valid), 64'(VEC[i].emv));
      if (VEC[i].emv) begin
        chk(mem_req_write == VEC[i].emw, {tag, " mem_req_write"},
            64'(mem_req_write), 64'(VEC[i].emw));
        chk(mem_req_addr == VEC[i].ema, {tag, " mem_req_addr"},
            64'(mem_req_addr), 64'(VEC[i].ema));
        if (VEC[i].emw)
          chk(mem_req_data == VEC[i].emd, {tag, " mem_req_data"},
              64'(mem_req_data), 64'(VEC[i].emd));
      end
      chk(rd_resp_valid == VEC[i].erv, {tag, " rd_resp_valid"},
          64'(rd_resp_valid), 64'(VEC[i].erv));
      if (VEC[i].erv)
        chk(rd_resp_data == VEC[i].erd, {tag, " rd_resp_data"},
            64'(rd_resp_data), 64'(VEC[i].erd));
      step();
    end
    wv = 0; rv = 0; mr = 0; mrv = 0;

    // R8: wait-for-empty mode holds the miss behind a queued store
    w_wv = 1; w_wa = 16'h30; w_wd = 32'h7; w_mr = 0;
    step();
    w_wv = 0; w_rv = 1; w_ra = 16'h40;
    #2;
    chk(w_wr_ready == 1'b0, "R9 wait wr_ready", 64'(w_wr_ready), 64'h0);
    step();
    w_rv = 0;
    for (int c = 0; c < 2; c++) begin
      #2;
      chk(w_mem_req_valid && w_mem_req_write && w_mem_req_addr == 16'h30,
          "R8 store still ahead", 64'({w_mem_req_write, w_mem_req_addr}),
          64'({1'b1, 16'h30}));
      step();
    end
    w_mr = 1;
    step();
    #2;
    chk(w_mem_req_valid == 1'b0, "R8 empty before issue",
        64'(w_mem_req_valid), 64'h0);
    step();
    #2;
    chk(w_mem_req_valid && !w_mem_req_write && w_mem_req_addr == 16'h40,
        "R8 read issued", 64'({w_mem_req_valid, w_mem_req_write, w_mem_req_addr}),
        64'({1'b1, 1'b0, 16'h40}));
    step();
    w_mr = 0; w_mrv = 1; w_mrd = 32'h99;
    step();
    w_mrv = 0;
    #2;
    chk(w_rd_resp_valid && w_rd_resp_data == 32'h99, "R7 wait resp",
        64'(w_rd_resp_data), 64'h99);
    step();
    #2;
    chk(w_rd_resp_valid == 1'b0, "R7 pulse ends", 64'(w_rd_resp_valid), 64'h0);

    // R1: reset in mid-operation empties the queue
    step();
    wv = 1; wa = 16'h50; wd = 32'h8; mr = 0;
    step();
    wv = 0;
    #2;
    chk(mem_req_valid == 1'b1, "R1 pre-reset queued", 64'(mem_req_valid), 64'h1);
    rst = 1;
    step();
    rst = 0;
    #2;
    chk(mem_req_valid == 1'b0, "R1 mid reset mem_req_valid", 64'(mem_req_valid), 64'h0);
    chk(wr_ready == 1'b1, "R1 mid reset wr_ready", 64'(wr_ready), 64'h1);
    step();
    finish_run();
  end
endmodule